// File: doc/BRIEF.md
# UART Transmit Line Encoder

This block sits between a UART transmit framer and the transmit pin. Each bit time the framer presents one bit together with a tag saying what kind of bit it is: idle, break, start, data, parity or stop. A 16x oversampling enable paces the encoder. It turns each bit into the level on the pin. The level is either a plain NRZ level or an IrDA-style short pulse, and either polarity can be chosen.

A polarity control flips the line. When smart-card mode is off, it flips everything, including the idle, start, stop and break levels. When smart-card mode is on, it flips only data and parity bits. In T=0 smart-card operation with initial-character detection enabled, a detection pulse turns the inversion on without software. A loopback output feeds the pin level to a receiver input, with a separate receive inversion applied as an XOR.

Top module: `uart_tx_line_encoder`

## Requirements
- R1: After reset, `txd` is 1 (NRZ format, idle level, no inversion), `rx_loop` is 1 and `tx_invert_eff` is 0.
- R2: In NRZ with no inversion, a logical one drives `txd` high and a logical zero drives it low. Bit kinds are encoded on `bit_kind` as 0 idle, 1 break, 2 start, 3 data, 4 parity, 5 stop, and codes 6 and 7 count as idle. Idle and stop are logical one, break and start are logical zero, and data and parity take `bit_val`.
- R3: With smart-card mode off and inversion in effect, every transmitted level is the complement of the R2 level, including idle, break, start and stop.
- R4: With smart-card mode on and inversion in effect, only data and parity bits are complemented. Idle, break, start and stop keep the R2 level.
- R5: In IrDA format with no inversion, a logical zero drives `txd` high on oversample ticks 7, 8 and 9 of the bit (ticks numbered 0 to 15) and low on all other ticks. A logical one keeps `txd` low for the whole bit.
- R6: In IrDA format with inversion in effect, the levels are the complement of R5: a zero gives a low pulse on ticks 7 to 9, and the line otherwise rests high.
- R7: Kind, value, format, smart-card mode and effective inversion are captured only on the oversample tick that starts a bit (tick 0). `txd` is registered and changes only in the clock after an `os_tick` cycle, to the level for that tick.
- R8: When `smartcard_en`, `initchar_det_en`, `t0_protocol` and `initchar_seen` are all 1 in one cycle, `tx_invert_eff` is 1 from the next cycle on. It stays 1 until `smartcard_en` is 0. At all times `tx_invert_eff` also follows `tx_invert_cfg`.
- R9: `rx_loop` equals `txd ^ rx_invert` while `loop_en` is 1, and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | 16x oversampling enable, one clock wide |
| bit_kind | input | 3 | Kind of the current bit (encoding in R2) |
| bit_val | input | 1 | Value of a data or parity bit |
| irda_mode | input | 1 | 1 selects IrDA pulse format, 0 selects NRZ |
| tx_invert_cfg | input | 1 | Software transmit inversion control |
| smartcard_en | input | 1 | Smart-card mode: inversion limited to data and parity |
| initchar_det_en | input | 1 | Enables automatic inversion on initial-character detection |
| t0_protocol | input | 1 | Smart-card T=0 protocol selected |
| initchar_seen | input | 1 | One-cycle pulse: inverse-convention initial character detected |
| loop_en | input | 1 | Loopback enable |
| rx_invert | input | 1 | Receive inversion applied on the loopback path |
| txd | output | 1 | Registered transmit pin level |
| rx_loop | output | 1 | Receiver input level from the loopback path |
| tx_invert_eff | output | 1 | Inversion currently in effect (software or automatic) |

## Verification
The assertions take for granted that `os_tick` is a single-cycle enable and that the framer holds `bit_kind`, `bit_val` and the mode inputs steady around the tick-0 sample. That tick is the only point where they matter, so changes elsewhere are legal. The stimulus stays inside this: it asserts `os_tick` on two of every three clocks and drives every input only at the falling edge. It also changes the kind, value and mode inputs deliberately in the middle of bits, so that the tick-0-only capture is exercised and not merely assumed. `initchar_seen` is driven as a one-cycle pulse, both with the qualifying conditions met and with them not met.

// File: rtl/uart_txenc_pkg.sv
package uart_txenc_pkg;

    typedef enum logic [2:0] {
        KIND_IDLE   = 3'd0,
        KIND_BREAK  = 3'd1,
        KIND_START  = 3'd2,
        KIND_DATA   = 3'd3,
        KIND_PARITY = 3'd4,
        KIND_STOP   = 3'd5
    } bit_kind_e;

    typedef struct packed {
        bit_kind_e kind;
        logic      value;
    } bit_slot_t;

    typedef struct packed {
        logic irda;
        logic smartcard;
        logic invert;
    } line_cfg_t;

    localparam bit_slot_t SLOT_IDLE = '{kind: KIND_IDLE, value: 1'b1};
    localparam line_cfg_t CFG_RESET = '{irda: 1'b0, smartcard: 1'b0, invert: 1'b0};

    function automatic logic logical_bit(bit_slot_t s);
        case (s.kind)
            KIND_BREAK, KIND_START:  return 1'b0;
            KIND_DATA, KIND_PARITY:  return s.value;
            default:                 return 1'b1;
        endcase
    endfunction

    function automatic logic kind_flips(bit_slot_t s, line_cfg_t c);
        return c.invert && (!c.smartcard || s.kind == KIND_DATA || s.kind == KIND_PARITY);
    endfunction

    function automatic logic line_level(bit_slot_t s, line_cfg_t c, logic in_window);
        logic b;
        b = logical_bit(s);
        if (c.irda)
            return (!b && in_window) ^ kind_flips(s, c);
        return b ^ kind_flips(s, c);
    endfunction

endpackage

// File: rtl/uart_txenc_phase.sv
module uart_txenc_phase #(
    parameter int OVS_RATE = 16,
    localparam int PHASE_W = $clog2(OVS_RATE)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               os_tick,
    output logic [PHASE_W-1:0] phase
);
    localparam logic [PHASE_W-1:0] LAST = PHASE_W'(OVS_RATE - 1);

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else if (os_tick)
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end

    assert_phase_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (os_tick && phase == LAST) |=> (phase == '0));

endmodule

// File: rtl/uart_txenc_invctl.sv
module uart_txenc_invctl (
    input  logic clk,
    input  logic rst,
    input  logic tx_invert_cfg,
    input  logic smartcard_en,
    input  logic initchar_det_en,
    input  logic t0_protocol,
    input  logic initchar_seen,
    output logic invert_eff
);
    logic auto_q;
    logic auto_hit;

    assign auto_hit   = smartcard_en && initchar_det_en && t0_protocol && initchar_seen;
    assign invert_eff = tx_invert_cfg | auto_q;

    always_ff @(posedge clk) begin
        if (rst || !smartcard_en)
            auto_q <= 1'b0;
        else if (auto_hit)
            auto_q <= 1'b1;
    end

    assert_auto_set_R8: assert property (@(posedge clk) disable iff (rst)
        auto_hit |=> invert_eff);

    assert_auto_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (auto_q && smartcard_en) |=> invert_eff);

endmodule

// File: rtl/uart_txenc_shaper.sv
module uart_txenc_shaper
    import uart_txenc_pkg::*;
#(
    parameter int OVS_RATE    = 16,
    parameter int PULSE_FIRST = 7,
    parameter int PULSE_TICKS = 3,
    localparam int PHASE_W    = $clog2(OVS_RATE),
    localparam int PULSE_LAST = PULSE_FIRST + PULSE_TICKS - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               os_tick,
    input  logic [PHASE_W-1:0] phase,
    input  bit_slot_t          slot_in,
    input  line_cfg_t          cfg_in,
    output logic               txd
);
    bit_slot_t slot_q;
    line_cfg_t cfg_q;
    bit_slot_t slot_now;
    line_cfg_t cfg_now;
    logic      boundary;
    logic      in_window;

    assign boundary  = (phase == '0);
    assign slot_now  = boundary ? slot_in : slot_q;
    assign cfg_now   = boundary ? cfg_in : cfg_q;
    assign in_window = (int'(phase) >= PULSE_FIRST) && (int'(phase) <= PULSE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= SLOT_IDLE;
            cfg_q  <= CFG_RESET;
            txd    <= 1'b1;
        end else if (os_tick) begin
            if (boundary) begin
                slot_q <= slot_in;
                cfg_q  <= cfg_in;
            end
            txd <= line_level(slot_now, cfg_now, in_window);
        end
    end

    assert_hold_between_ticks_R7: assert property (@(posedge clk) disable iff (rst)
        !os_tick |=> $stable(txd));

    assert_sc_start_plain_R4: assert property (@(posedge clk) disable iff (rst)
        (os_tick && boundary && !cfg_in.irda && cfg_in.smartcard && slot_in.kind == KIND_START)
        |=> !txd);

    assert_nrz_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (os_tick && boundary && !cfg_in.irda && !cfg_in.smartcard && slot_in.kind == KIND_IDLE)
        |=> (txd == !cfg_in.invert));

    assert_irda_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (os_tick && !in_window && cfg_now.irda && !cfg_now.invert) |=> !txd);

endmodule

// File: rtl/uart_tx_line_encoder.sv
module uart_tx_line_encoder
    import uart_txenc_pkg::*;
#(
    parameter int OVS_RATE    = 16,
    parameter int PULSE_FIRST = 7,
    parameter int PULSE_TICKS = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic [2:0] bit_kind,
    input  logic       bit_val,
    input  logic       irda_mode,
    input  logic       tx_invert_cfg,
    input  logic       smartcard_en,
    input  logic       initchar_det_en,
    input  logic       t0_protocol,
    input  logic       initchar_seen,
    input  logic       loop_en,
    input  logic       rx_invert,
    output logic       txd,
    output logic       rx_loop,
    output logic       tx_invert_eff
);
    localparam int PHASE_W = $clog2(OVS_RATE);

    logic [PHASE_W-1:0] phase;
    bit_slot_t          slot_in;
    line_cfg_t          cfg_in;

    assign slot_in = '{kind: bit_kind_e'(bit_kind), value: bit_val};
    assign cfg_in  = '{irda: irda_mode, smartcard: smartcard_en, invert: tx_invert_eff};

    uart_txenc_phase #(.OVS_RATE(OVS_RATE)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .os_tick (os_tick),
        .phase   (phase)
    );

    uart_txenc_invctl u_invctl (
        .clk             (clk),
        .rst             (rst),
        .tx_invert_cfg   (tx_invert_cfg),
        .smartcard_en    (smartcard_en),
        .initchar_det_en (initchar_det_en),
        .t0_protocol     (t0_protocol),
        .initchar_seen   (initchar_seen),
        .invert_eff      (tx_invert_eff)
    );

    uart_txenc_shaper #(
        .OVS_RATE    (OVS_RATE),
        .PULSE_FIRST (PULSE_FIRST),
        .PULSE_TICKS (PULSE_TICKS)
    ) u_shaper (
        .clk     (clk),
        .rst     (rst),
        .os_tick (os_tick),
        .phase   (phase),
        .slot_in (slot_in),
        .cfg_in  (cfg_in),
        .txd     (txd)
    );

    assign rx_loop = loop_en ? (txd ^ rx_invert) : 1'b1;

    assert_loop_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!loop_en && $stable(loop_en)) |-> rx_loop);

endmodule

// File: tb/uart_tx_line_encoder_bench.sv
module uart_tx_line_encoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic os_tick = 1'b0;
    logic [2:0] bit_kind = 3'd0;
    logic bit_val = 1'b0;
    logic irda_mode = 1'b0;
    logic tx_invert_cfg = 1'b0;
    logic smartcard_en = 1'b0;
    logic initchar_det_en = 1'b0;
    logic t0_protocol = 1'b0;
    logic initchar_seen = 1'b0;
    logic loop_en = 1'b0;
    logic rx_invert = 1'b0;
    logic txd, rx_loop, tx_invert_eff;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;
    string cur_req = "R1";

    int m_cnt, m_kind, m_val, m_irda, m_sc, m_inv, m_auto, m_txd;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_tx_line_encoder u_uart_tx_line_encoder (
        .clk(clk), .rst(rst), .os_tick(os_tick), .bit_kind(bit_kind), .bit_val(bit_val),
        .irda_mode(irda_mode), .tx_invert_cfg(tx_invert_cfg), .smartcard_en(smartcard_en),
        .initchar_det_en(initchar_det_en), .t0_protocol(t0_protocol),
        .initchar_seen(initchar_seen), .loop_en(loop_en), .rx_invert(rx_invert),
        .txd(txd), .rx_loop(rx_loop), .tx_invert_eff(tx_invert_eff)
    );

    function automatic int ref_level(int kind, int val, int irda, int sc, int inv, int tick);
        int lb, flip, pulse;
        if (kind == 1 || kind == 2) lb = 0;
        else if (kind == 3 || kind == 4) lb = val;
        else lb = 1;
        flip = (inv != 0 && (sc == 0 || kind == 3 || kind == 4)) ? 1 : 0;
        if (irda != 0) begin
            pulse = (lb == 0 && tick >= 7 && tick <= 9) ? 1 : 0;
            return pulse ^ flip;
        end
        return lb ^ flip;
    endfunction

    always @(posedge clk) begin
        int eff_old;
        cyc++;
        if (rst) begin
            m_cnt = 0; m_kind = 0; m_val = 1; m_irda = 0; m_sc = 0; m_inv = 0;
            m_auto = 0; m_txd = 1;
        end else begin
            eff_old = (tx_invert_cfg || m_auto != 0) ? 1 : 0;
            if (os_tick) begin
                if (m_cnt == 0) begin
                    m_kind = int'(bit_kind); m_val = int'(bit_val);
                    m_irda = int'(irda_mode); m_sc = int'(smartcard_en); m_inv = eff_old;
                end
                m_txd = ref_level(m_kind, m_val, m_irda, m_sc, m_inv, m_cnt);
                m_cnt = (m_cnt + 1) % 16;
            end
            if (!smartcard_en) m_auto = 0;
            else if (initchar_det_en && t0_protocol && initchar_seen) m_auto = 1;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    task automatic step();
        int exp_eff, exp_loop;
        @(negedge clk);
        if (!rst) begin
            exp_eff  = (tx_invert_cfg || m_auto != 0) ? 1 : 0;
            exp_loop = loop_en ? (m_txd ^ int'(rx_invert)) : 1;
            check(cur_req, "txd", int'(txd), m_txd);
            check("R9", "rx_loop", int'(rx_loop), exp_loop);
            check("R8", "tx_invert_eff", int'(tx_invert_eff), exp_eff);
        end
        os_tick = (cyc % 3 != 2);
        initchar_seen = 1'b0;
    endtask

    task automatic hold(int kind, int val, int ncyc);
        bit_kind = 3'(kind);
        bit_val  = 1'(val);
        for (int i = 0; i < ncyc; i++) step();
    endtask

    task automatic frame();
        hold(0, 1, 30); hold(2, 0, 24); hold(3, 1, 24); hold(3, 0, 24);
        hold(3, 1, 24); hold(4, 0, 24); hold(5, 1, 24); hold(1, 0, 48);
        hold(6, 0, 24); hold(7, 1, 24); hold(0, 1, 24);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "txd after reset", int'(txd), 1);
        check("R1", "rx_loop after reset", int'(rx_loop), 1);
        check("R1", "tx_invert_eff after reset", int'(tx_invert_eff), 0);

        cur_req = "R2"; frame();
        cur_req = "R3"; tx_invert_cfg = 1'b1; frame();
        cur_req = "R4"; smartcard_en = 1'b1; frame();
        smartcard_en = 1'b0;
        cur_req = "R5"; tx_invert_cfg = 1'b0; irda_mode = 1'b1; frame();
        cur_req = "R6"; tx_invert_cfg = 1'b1; frame();

        cur_req = "R7";
        for (int i = 0; i < 40; i++) begin
            irda_mode = 1'(i % 4 == 1);
            tx_invert_cfg = 1'(i % 3 == 0);
            smartcard_en = 1'(i % 5 == 2);
            hold(i % 8, i % 2, 5 + (i % 7));
        end
        irda_mode = 1'b0; tx_invert_cfg = 1'b0; smartcard_en = 1'b0;
        hold(0, 1, 40);

        cur_req = "R8";
        smartcard_en = 1'b1; initchar_det_en = 1'b1; t0_protocol = 1'b0;
        hold(3, 0, 10);
        initchar_seen = 1'b1; step();
        check("R8", "no auto set without T=0", int'(tx_invert_eff), 0);
        t0_protocol = 1'b1;
        hold(3, 0, 7);
        initchar_seen = 1'b1; step();
        check("R8", "auto set after detection", int'(tx_invert_eff), 1);
        hold(2, 0, 30); hold(3, 1, 30); hold(3, 0, 30);
        smartcard_en = 1'b0; step();
        check("R8", "auto cleared with smart-card off", int'(tx_invert_eff), 0);
        initchar_seen = 1'b1; step();
        check("R8", "no auto set with smart-card off", int'(tx_invert_eff), 0);
        hold(0, 1, 20);

        cur_req = "R9";
        loop_en = 1'b1; hold(3, 0, 40);
        tx_invert_cfg = 1'b1; hold(3, 1, 40);
        rx_invert = 1'b1; hold(2, 0, 40);
        irda_mode = 1'b1; hold(3, 0, 60);
        loop_en = 1'b0; hold(0, 1, 20);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        if (!done && cyc > WATCHDOG) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule